// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 64 level-sensitive request lines and turns them into two processor request outputs: a normal request (`irqOut`) and a fast request (`fiqOut`). For each line, software picks whether it is enabled and which output it drives. It can also raise the line from software. Each line routed to the normal output carries a 4-bit priority. A global threshold silences any normal line whose priority does not exceed it.

Software reaches the block through a plain single-cycle register port. Writes are stored on the rising clock edge while `wrEn` is high. Reads are combinational from `addr`. Addresses are word indices. Status words show which lines are pending on each output. An index word holds the number of the winning normal line, so software can use it directly to look up a handler table. A single control bit gates each output as a whole.

Top module: `prio_intc`

## Requirements
- R1: A line requests when its input or its force bit is 1 and its enable bit is 1. A line whose enable bit is 0 never raises an output.
- R2: When a requesting line's route bit is 1, it drives `fiqOut`. When the route bit is 0, it drives `irqOut`.
- R3: A normal line counts only when its 4-bit priority is strictly greater than the mask level. It is blocked when its priority is less than or equal to the mask. This means priority 0 is always blocked.
- R4: The index word (address 12) holds the number of the pending normal line with the highest priority. When two lines tie, the higher line number wins. The word reads 32'hFFFF_FFFF when no normal line is pending.
- R5: Normal pending words (addresses 8 and 9) show the normal lines that pass R3. Fast pending words (addresses 10 and 11) show the requesting fast lines. Bit b of the first word of each pair is line b, and bit b of the second word is line 32+b.
- R6: Control word (address 0) bit 0 holds `irqOut` low and bit 1 holds `fiqOut` low. Neither bit changes the pending words or the index word.
- R7: Both outputs are registered. A change on an input line appears at the outputs one clock edge later. A register write appears at the outputs on the edge after the edge that stores it.
- R8: After reset, every register is zero, both outputs are low, and the index word reads 32'hFFFF_FFFF.
- R9: The register words read back what was written. The layout is: control at 0 with bits [1:0]; mask at 1 with bits [3:0]; enable at 2 and 3; route at 4 and 5; force at 6 and 7; and priority at 16 through 23. In priority word 16+k, line 8k+j sits in bits [4j+3:4j].
- R10: A force bit raises its line with the input held low, under the same enable, route and priority rules as a real input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 64 | Level-sensitive request lines |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Register word index |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data (combinational) |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
A line can change in the same cycle that software rewrites the mask. The bench provokes this by raising a priority-7 line on the same clock edge that stores a mask of 7. It expects `irqOut` to go high after that edge, because the output was sampled with the old mask. It then expects `irqOut` to fall one edge later. Equal-priority ties and a force bit arriving in the same cycle as route changes are covered by table rows. Each row checks both outputs and the index word against values computed by hand.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 4;
  localparam int PRIO_PER_WORD = DATA_W / PRIO_W;
  localparam int ADDR_W = 6;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_MASK, K_ENB, K_FSEL, K_FORCE,
    K_NPEND, K_FPEND, K_IDX, K_PRIO
  } regKind_e;

  typedef struct packed {
    logic              wr;
    regKind_e          kind;
    logic [ADDR_W-1:0] sel;
  } regStrobe_t;
endpackage

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [PRIO_W-1:0]  maskLvl,
  output logic [DATA_W-1:0]  rdData,
  output logic               anyNorm,
  output logic               anyFast
);
  localparam int WORDS = NUM_SRC / DATA_W;
  localparam int PWORDS = NUM_SRC / PRIO_PER_WORD;
  localparam int WSEL = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int PSEL = (PWORDS > 1) ? $clog2(PWORDS) : 1;
  localparam int IDXW = $clog2(NUM_SRC);

  logic [WORDS-1:0][DATA_W-1:0] enbW, fselW, forceW, normPendW, fastPendW;
  logic [PRIO_W-1:0] prioQ [NUM_SRC];
  logic [PWORDS-1:0][DATA_W-1:0] prioWord;
  logic [NUM_SRC-1:0] enbV, fselV, forceV, effReq, normPend, fastPend;
  logic found;
  logic [PRIO_W-1:0] bestP;
  logic [IDXW-1:0] bestIdx;
  logic [DATA_W-1:0] idxWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enbW <= '0;
      fselW <= '0;
      forceW <= '0;
      for (int i = 0; i < NUM_SRC; i++) prioQ[i] <= '0;
    end else if (strb.wr) begin
      for (int w = 0; w < WORDS; w++) begin
        if (strb.sel == ADDR_W'(w)) begin
          case (strb.kind)
            K_ENB:   enbW[w] <= wrData;
            K_FSEL:  fselW[w] <= wrData;
            K_FORCE: forceW[w] <= wrData;
            default: ;
          endcase
        end
      end
      for (int p = 0; p < PWORDS; p++) begin
        if (strb.kind == K_PRIO && strb.sel == ADDR_W'(p)) begin
          for (int j = 0; j < PRIO_PER_WORD; j++)
            prioQ[p*PRIO_PER_WORD+j] <= wrData[j*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  assign enbV = enbW;
  assign fselV = fselW;
  assign forceV = forceW;
  assign effReq = (srcIn | forceV) & enbV;
  assign fastPend = effReq & fselV;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      normPend[i] = effReq[i] & ~fselV[i] & (prioQ[i] > maskLvl);
  end

  assign normPendW = normPend;
  assign fastPendW = fastPend;
  assign anyNorm = |normPend;
  assign anyFast = |fastPend;

  // Later lines win ties because of the >= comparison in an ascending scan.
  always_comb begin
    found = 1'b0;
    bestP = '0;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (normPend[i] && (!found || prioQ[i] >= bestP)) begin
        found = 1'b1;
        bestP = prioQ[i];
        bestIdx = IDXW'(i);
      end
    end
  end

  assign idxWord = found ? DATA_W'(bestIdx) : '1;

  generate
    for (genvar p = 0; p < PWORDS; p++) begin : g_pword
      for (genvar j = 0; j < PRIO_PER_WORD; j++) begin : g_field
        assign prioWord[p][j*PRIO_W +: PRIO_W] = prioQ[p*PRIO_PER_WORD+j];
      end
    end
  endgenerate

  always_comb begin
    case (strb.kind)
      K_ENB:   rdData = enbW[strb.sel[WSEL-1:0]];
      K_FSEL:  rdData = fselW[strb.sel[WSEL-1:0]];
      K_FORCE: rdData = forceW[strb.sel[WSEL-1:0]];
      K_NPEND: rdData = normPendW[strb.sel[WSEL-1:0]];
      K_FPEND: rdData = fastPendW[strb.sel[WSEL-1:0]];
      K_IDX:   rdData = idxWord;
      K_PRIO:  rdData = prioWord[strb.sel[PSEL-1:0]];
      default: rdData = '0;
    endcase
  end

  // R4
  idx_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (enbV[bestIdx] && !fselV[bestIdx]));
  // R3
  idx_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (prioQ[bestIdx] > maskLvl));
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] dpRdData,
  input  logic              anyNorm,
  input  logic              anyFast,
  output regStrobe_t        strb,
  output logic [PRIO_W-1:0] maskLvl,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              fiqOut
);
  localparam int WORDS = NUM_SRC / DATA_W;
  localparam int PWORDS = NUM_SRC / PRIO_PER_WORD;
  localparam int ENB_B = 2;
  localparam int FSEL_B = ENB_B + WORDS;
  localparam int FORCE_B = FSEL_B + WORDS;
  localparam int NPEND_B = FORCE_B + WORDS;
  localparam int FPEND_B = NPEND_B + WORDS;
  localparam int IDX_A = FPEND_B + WORDS;
  localparam int PRIO_B = 16;

  logic irqOff, fiqOff;
  int a;

  always_comb begin
    a = int'(addr);
    strb.wr = wrEn;
    strb.kind = K_NONE;
    strb.sel = '0;
    if (a == 0) strb.kind = K_CTRL;
    else if (a == 1) strb.kind = K_MASK;
    else if (a >= ENB_B && a < FSEL_B) begin
      strb.kind = K_ENB; strb.sel = addr - ADDR_W'(ENB_B);
    end else if (a >= FSEL_B && a < FORCE_B) begin
      strb.kind = K_FSEL; strb.sel = addr - ADDR_W'(FSEL_B);
    end else if (a >= FORCE_B && a < NPEND_B) begin
      strb.kind = K_FORCE; strb.sel = addr - ADDR_W'(FORCE_B);
    end else if (a >= NPEND_B && a < FPEND_B) begin
      strb.kind = K_NPEND; strb.sel = addr - ADDR_W'(NPEND_B);
    end else if (a >= FPEND_B && a < IDX_A) begin
      strb.kind = K_FPEND; strb.sel = addr - ADDR_W'(FPEND_B);
    end else if (a == IDX_A) strb.kind = K_IDX;
    else if (a >= PRIO_B && a < PRIO_B + PWORDS) begin
      strb.kind = K_PRIO; strb.sel = addr - ADDR_W'(PRIO_B);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOff <= 1'b0;
      fiqOff <= 1'b0;
      maskLvl <= '0;
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      if (wrEn && strb.kind == K_CTRL) begin
        irqOff <= wrData[0];
        fiqOff <= wrData[1];
      end
      if (wrEn && strb.kind == K_MASK) maskLvl <= wrData[PRIO_W-1:0];
      irqOut <= anyNorm & ~irqOff;
      fiqOut <= anyFast & ~fiqOff;
    end
  end

  always_comb begin
    case (strb.kind)
      K_CTRL:  rdData = {{(DATA_W-2){1'b0}}, fiqOff, irqOff};
      K_MASK:  rdData = {{(DATA_W-PRIO_W){1'b0}}, maskLvl};
      default: rdData = dpRdData;
    endcase
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(!irqOff));
  // R6
  fiq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> $past(!fiqOff));
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(anyNorm));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut
);
  regStrobe_t strb;
  logic [PRIO_W-1:0] maskLvl;
  logic [DATA_W-1:0] dpRdData;
  logic anyNorm, anyFast;

  intc_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .dpRdData(dpRdData), .anyNorm(anyNorm), .anyFast(anyFast),
    .strb(strb), .maskLvl(maskLvl), .rdData(rdData),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  intc_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .srcIn(srcIn),
    .maskLvl(maskLvl), .rdData(dpRdData), .anyNorm(anyNorm), .anyFast(anyFast)
  );
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] enb, fsel, frc, src;
    logic [3:0]  mask;
    logic        irq, fiq;
    logic [31:0] idx;
  } vec_t;

  // Priorities are set to (line mod 16) before the table runs.
  localparam vec_t VECS [13] = '{
    '{64'h0, 64'h0, 64'h0, 64'h0, 4'd0, 1'b0, 1'b0, 32'hFFFF_FFFF},
    '{'1, 64'h0, 64'h0, 64'h20, 4'd0, 1'b1, 1'b0, 32'd5},
    '{'1, 64'h0, 64'h0, 64'h20_0020, 4'd0, 1'b1, 1'b0, 32'd21},
    '{'1, 64'h0, 64'h0, 64'h4_0008, 4'd0, 1'b1, 1'b0, 32'd3},
    '{'1, 64'h0, 64'h0, 64'h1_0000, 4'd0, 1'b0, 1'b0, 32'hFFFF_FFFF},
    '{'1, 64'h0, 64'h0, 64'h0000_0100_0000_0080, 4'd7, 1'b1, 1'b0, 32'd40},
    '{'1, 64'h0, 64'h0, 64'h0000_0100_0000_0080, 4'd8, 1'b0, 1'b0, 32'hFFFF_FFFF},
    '{64'hFFFF_FEFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0000_0100_0000_0080, 4'd0, 1'b1, 1'b0, 32'd7},
    '{'1, 64'h0, 64'h1000, 64'h0, 4'd0, 1'b1, 1'b0, 32'd12},
    '{'1, 64'h1000, 64'h1000, 64'h0, 4'd0, 1'b0, 1'b1, 32'hFFFF_FFFF},
    '{'1, 64'h8000_0000_0000_0000, 64'h0, 64'hC000_0000_0000_0000, 4'd0, 1'b1, 1'b1, 32'd62},
    '{64'h0, 64'h0, '1, 64'h0, 4'd0, 1'b0, 1'b0, 32'hFFFF_FFFF},
    '{'1, 64'h0, 64'h0, '1, 4'd14, 1'b1, 1'b0, 32'd63}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic wrEn = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut, fiqOut;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  prio_intc u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8 irq", {31'd0, irqOut}, 32'd0);
    chk("R8 fiq", {31'd0, fiqOut}, 32'd0);
    rd(6'd12, rv); chk("R8 idx", rv, 32'hFFFF_FFFF);
    rd(6'd2, rv);  chk("R8 enb", rv, 32'd0);

    // R9: priority layout and readback
    for (int p = 0; p < 8; p++) wr(6'(16 + p), (p % 2 == 0) ? 32'h7654_3210 : 32'hFEDC_BA98);
    rd(6'd16, rv); chk("R9 prio16", rv, 32'h7654_3210);
    rd(6'd23, rv); chk("R9 prio23", rv, 32'hFEDC_BA98);
    wr(6'd0, 32'h3);
    rd(6'd0, rv); chk("R9 ctrl", rv, 32'h3);
    wr(6'd0, 32'h0);
    wr(6'd1, 32'hFFFF_FFF5);
    rd(6'd1, rv); chk("R9 mask", rv, 32'h5);
    wr(6'd5, 32'hA5A5_0001);
    rd(6'd5, rv); chk("R9 route", rv, 32'hA5A5_0001);

    // Table: R1 R2 R3 R4 R10
    foreach (VECS[v]) begin
      wr(6'd2, VECS[v].enb[31:0]);  wr(6'd3, VECS[v].enb[63:32]);
      wr(6'd4, VECS[v].fsel[31:0]); wr(6'd5, VECS[v].fsel[63:32]);
      wr(6'd6, VECS[v].frc[31:0]);  wr(6'd7, VECS[v].frc[63:32]);
      wr(6'd1, {28'd0, VECS[v].mask});
      srcIn = VECS[v].src;
      @(negedge clk);
      chk($sformatf("R2 R1 R3 irq row %0d", v), {31'd0, irqOut}, {31'd0, VECS[v].irq});
      chk($sformatf("R2 R10 fiq row %0d", v), {31'd0, fiqOut}, {31'd0, VECS[v].fiq});
      rd(6'd12, rv); chk($sformatf("R4 idx row %0d", v), rv, VECS[v].idx);
    end

    // R5: pending words, line 1 fast, line 2 normal, line 16 blocked (prio 0)
    srcIn = '0;
    wr(6'd2, '1); wr(6'd3, '1); wr(6'd4, 32'h2); wr(6'd5, 32'h0);
    wr(6'd6, 32'h0); wr(6'd7, 32'h0); wr(6'd1, 32'h0);
    srcIn = 64'h1_0006;
    @(negedge clk);
    rd(6'd8, rv);  chk("R5 npend", rv, 32'h4);
    rd(6'd10, rv); chk("R5 fpend", rv, 32'h2);

    // R6: global disables
    wr(6'd0, 32'h3);
    @(negedge clk);
    chk("R6 irq off", {31'd0, irqOut}, 32'd0);
    chk("R6 fiq off", {31'd0, fiqOut}, 32'd0);
    rd(6'd8, rv);  chk("R6 npend kept", rv, 32'h4);
    rd(6'd12, rv); chk("R6 idx kept", rv, 32'd2);
    wr(6'd0, 32'h0);
    @(negedge clk);
    chk("R6 irq back", {31'd0, irqOut}, 32'd1);
    chk("R6 fiq back", {31'd0, fiqOut}, 32'd1);

    // R7: one-edge latency on a line change
    srcIn = '0;
    @(negedge clk);
    srcIn = 64'h20;
    #1; chk("R7 before edge", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    chk("R7 after edge", {31'd0, irqOut}, 32'd1);
    srcIn = '0;
    #1; chk("R7 hold", {31'd0, irqOut}, 32'd1);
    @(negedge clk);
    chk("R7 fall", {31'd0, irqOut}, 32'd0);

    // R7 R3: line 7 rises in the same cycle that mask 7 is stored
    srcIn = 64'h80;
    wr(6'd1, 32'd7);
    chk("R7 old mask seen", {31'd0, irqOut}, 32'd1);
    @(negedge clk);
    chk("R3 new mask blocks", {31'd0, irqOut}, 32'd0);

    finishRun();
  end
endmodule